// File: doc/BRIEF.md
# Card Clock Divider with Committed Updates

This unit derives a card clock from the source clock `clk`. The card clock can be divided down, passed straight through, or gated off. Software writes new settings into staging registers: one 8-bit divider field per divider, a selector that picks which divider feeds the output, and a gate bit. None of these writes touches the running clock. The settings move into the active configuration only when a command with the start bit set is written. The start bit then reads back as 1 until the unit accepts the command. A command can ask the unit to hold off while the external data-busy input is high.

If a new command is written while an older one is still pending, the new command is dropped and a sticky lock-error flag is set. The clock generator picks up a new active configuration only while the card clock is low, so a setting change never produces a short high pulse.

Top module: `clkdiv_update_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `card_clk` is low.
- R2: Writes go to staging registers. Address 0 holds divider field i in bits 8i+7..8i. Address 1 holds the selector in its low bits. Address 2 holds the gate in bit 0. Each register reads back what was written, and `card_clk` does not change until a command applies the value.
- R3: Writing address 3 with bit 31 set, while nothing is pending, makes bit 31 read 1 from the next cycle. Bits 21 and 13 read back the captured options. Bit 31 clears on the first edge where the command is not deferred.
- R4: An accepted command with bit 21 (update-only) set copies all staged values into the active configuration in the same edge.
- R5: With the gate on and a selected divider d from 1 to 255, `card_clk` is high for d source cycles and then low for d source cycles.
- R6: With the gate on and a selected divider of 0, `card_clk` follows `clk`.
- R7: With the gate off, `card_clk` stays low.
- R8: The active selector picks which divider field drives `card_clk`.
- R9: A command written while another is pending is discarded: the captured options do not change. It also sets the lock flag, address 4 bit 12. The flag stays set until 1 is written to that bit.
- R10: If the captured bit 13 is set, acceptance waits while `data_busy` is high. If bit 13 is clear, `data_busy` has no effect. Address 5 bit 9 reads `data_busy`.
- R11: An accepted command without bit 21 clears bit 31 and leaves the active configuration unchanged.
- R12: The generator switches to a new configuration only while `card_clk` is low. The new configuration then starts with a full low half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| data_busy | input | 1 | Data transfer in progress |
| card_clk | output | 1 | Divided and gated card clock |

## Verification
The bench builds the unit with two divider fields, so the selector moves the output between two distinct rates, and R8 shows up directly as a change in the number of card-clock rising edges. The 8-bit divider width lets the bench check both ends of the range: 0 (pass-through) and 255, a full period of 510 source cycles. It also checks a switch made mid-period from a slow rate to a fast one, where a short high pulse would appear if the generator reloaded at the wrong time.

// File: rtl/ccu_pkg.sv
`timescale 1ns/100ps
package ccu_pkg;

    localparam int DIV_W = 8;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        RA_DIV  = 3'd0,
        RA_SRC  = 3'd1,
        RA_GATE = 3'd2,
        RA_CMD  = 3'd3,
        RA_INT  = 3'd4,
        RA_STAT = 3'd5
    } reg_addr_e;

    localparam int BIT_GO      = 31;
    localparam int BIT_UPD     = 21;
    localparam int BIT_HOLD    = 13;
    localparam int BIT_LOCK    = 12;
    localparam int BIT_BUSY    = 9;
    localparam int BIT_GATE_ON = 0;

    typedef struct packed {
        logic upd_only;
        logic hold_busy;
    } cmd_opt_t;

    function automatic cmd_opt_t opt_from_word(input logic [REG_W-1:0] w);
        cmd_opt_t o;
        o.upd_only  = w[BIT_UPD];
        o.hold_busy = w[BIT_HOLD];
        return o;
    endfunction

    function automatic logic is_go(input logic we, input logic [2:0] a,
                                   input logic [REG_W-1:0] w);
        return we && (a == RA_CMD) && w[BIT_GO];
    endfunction

endpackage

// File: rtl/ccu_stage_regs.sv
`timescale 1ns/100ps
module ccu_stage_regs
    import ccu_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int SRC_W   = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [2:0]                        addr,
    input  logic [REG_W-1:0]                  wdata,
    input  logic                              pending,
    input  cmd_opt_t                          opt,
    input  logic                              lock_err,
    input  logic                              data_busy,
    output logic [NUM_SRC-1:0][DIV_W-1:0]     stg_div,
    output logic [SRC_W-1:0]                  stg_src,
    output logic                              stg_en,
    output logic [REG_W-1:0]                  rdata
);

    localparam int DIVS_W = NUM_SRC * DIV_W;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_div[g] <= '0;
            end else if (wr_en && addr == RA_DIV) begin
                stg_div[g] <= wdata[g*DIV_W +: DIV_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_src <= '0;
            stg_en  <= 1'b0;
        end else if (wr_en) begin
            if (addr == RA_SRC)  stg_src <= wdata[SRC_W-1:0];
            if (addr == RA_GATE) stg_en  <= wdata[BIT_GATE_ON];
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_DIV:  rdata[DIVS_W-1:0] = stg_div;
            RA_SRC:  rdata[SRC_W-1:0]  = stg_src;
            RA_GATE: rdata[BIT_GATE_ON] = stg_en;
            RA_CMD: begin
                rdata[BIT_GO]   = pending;
                rdata[BIT_UPD]  = opt.upd_only;
                rdata[BIT_HOLD] = opt.hold_busy;
            end
            RA_INT:  rdata[BIT_LOCK] = lock_err;
            RA_STAT: rdata[BIT_BUSY] = data_busy;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ccu_update_ctrl.sv
`timescale 1ns/100ps
module ccu_update_ctrl
    import ccu_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int SRC_W   = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [2:0]                        addr,
    input  logic [REG_W-1:0]                  wdata,
    input  logic                              data_busy,
    input  logic [NUM_SRC-1:0][DIV_W-1:0]     stg_div,
    input  logic [SRC_W-1:0]                  stg_src,
    input  logic                              stg_en,
    output logic                              pending,
    output cmd_opt_t                          opt,
    output logic                              lock_err,
    output logic [NUM_SRC-1:0][DIV_W-1:0]     act_div,
    output logic [SRC_W-1:0]                  act_src,
    output logic                              act_en,
    output logic [DIV_W-1:0]                  sel_div
);

    logic go;
    logic deferred;
    logic accept;
    logic clr_lock;

    assign go       = is_go(wr_en, addr, wdata);
    assign deferred = opt.hold_busy && data_busy;
    assign accept   = pending && !deferred;
    assign clr_lock = wr_en && (addr == RA_INT) && wdata[BIT_LOCK];

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            opt      <= '0;
            lock_err <= 1'b0;
            act_div  <= '0;
            act_src  <= '0;
            act_en   <= 1'b0;
        end else begin
            if (accept) begin
                pending <= 1'b0;
                if (opt.upd_only) begin
                    act_div <= stg_div;
                    act_src <= stg_src;
                    act_en  <= stg_en;
                end
            end
            if (go && !pending) begin
                pending <= 1'b1;
                opt     <= opt_from_word(wdata);
            end
            if (go && pending) begin
                lock_err <= 1'b1;
            end else if (clr_lock) begin
                lock_err <= 1'b0;
            end
        end
    end

    always_comb begin
        sel_div = act_div[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_src == SRC_W'(i)) sel_div = act_div[i];
        end
    end

endmodule

// File: rtl/ccu_clk_gen.sv
`timescale 1ns/100ps
module ccu_clk_gen
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             half_q,
    output logic             byp_on,
    output logic [DIV_W:0]   run_key
);

    logic             run_en;
    logic [DIV_W-1:0] run_div;
    logic [DIV_W-1:0] cnt;
    logic             cfg_diff;
    logic             idle;

    assign cfg_diff = (cfg_en != run_en) || (cfg_div != run_div);
    assign idle     = !run_en || (run_div == '0);
    assign byp_on   = run_en && (run_div == '0);
    assign run_key  = {run_en, run_div};

    always_ff @(negedge clk) begin
        if (rst) begin
            run_en  <= 1'b0;
            run_div <= '0;
            cnt     <= '0;
            half_q  <= 1'b0;
        end else if (!half_q && cfg_diff) begin
            run_en  <= cfg_en;
            run_div <= cfg_div;
            cnt     <= '0;
            half_q  <= 1'b0;
        end else if (idle) begin
            cnt    <= '0;
            half_q <= 1'b0;
        end else if (cnt == run_div - DIV_W'(1)) begin
            cnt    <= '0;
            half_q <= !half_q;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/clkdiv_update_unit.sv
`timescale 1ns/100ps
module clkdiv_update_unit
    import ccu_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              data_busy,
    output logic              card_clk
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0][DIV_W-1:0] stg_div;
    logic [SRC_W-1:0]              stg_src;
    logic                          stg_en;
    logic                          pending;
    cmd_opt_t                      opt;
    logic                          lock_err;
    logic [NUM_SRC-1:0][DIV_W-1:0] act_div;
    logic [SRC_W-1:0]              act_src;
    logic                          act_en;
    logic [DIV_W-1:0]              sel_div;
    logic                          half_q;
    logic                          byp_on;
    logic [DIV_W:0]                run_key;

    ccu_stage_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pending(pending), .opt(opt), .lock_err(lock_err), .data_busy(data_busy),
        .stg_div(stg_div), .stg_src(stg_src), .stg_en(stg_en), .rdata(rdata)
    );

    ccu_update_ctrl #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .data_busy(data_busy), .stg_div(stg_div), .stg_src(stg_src),
        .stg_en(stg_en), .pending(pending), .opt(opt), .lock_err(lock_err),
        .act_div(act_div), .act_src(act_src), .act_en(act_en), .sel_div(sel_div)
    );

    ccu_clk_gen u_gen (
        .clk(clk), .rst(rst), .cfg_en(act_en), .cfg_div(sel_div),
        .half_q(half_q), .byp_on(byp_on), .run_key(run_key)
    );

    assign card_clk = byp_on ? clk : half_q;

endmodule

// File: rtl/ccu_checker.sv
`timescale 1ns/100ps
module ccu_checker #(
    parameter int CFG_W = 18,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [31:0]      wdata,
    input logic             data_busy,
    input logic             pending,
    input logic             hold_busy,
    input logic             lock_err,
    input logic [CFG_W-1:0] act_cfg,
    input logic             half_q,
    input logic [DIV_W:0]   run_key
);

    p_overlap_locks_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd3 && wdata[31] && pending) |=> lock_err);

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_err && !(wr_en && addr == 3'd4 && wdata[12])) |=> lock_err);

    p_busy_defers_r10: assert property (@(posedge clk) disable iff (rst)
        (pending && hold_busy && data_busy) |=> pending);

    p_accept_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (pending && !(hold_busy && data_busy)) |=> !pending);

    p_cfg_moves_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        !(pending && !(hold_busy && data_busy)) |=> $stable(act_cfg));

    p_reload_in_low_r12: assert property (@(negedge clk) disable iff (rst)
        !$stable(run_key) |-> ($past(half_q) == 1'b0 && !half_q));

endmodule

bind clkdiv_update_unit ccu_checker #(
    .CFG_W(NUM_SRC * ccu_pkg::DIV_W + SRC_W + 1),
    .DIV_W(ccu_pkg::DIV_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_busy(data_busy), .pending(pending), .hold_busy(opt.hold_busy),
    .lock_err(lock_err), .act_cfg({act_en, act_src, act_div}),
    .half_q(half_q), .run_key(run_key)
);

// File: tb/sim_clkdiv_update_unit.sv
`timescale 1ns/100ps
module sim_clkdiv_update_unit;

    localparam logic [31:0] GO  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h0020_0000;
    localparam logic [31:0] HLD = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic        data_busy = 1'b0;
    logic [31:0] rdata;
    logic        card_clk;

    always #2 clk = ~clk;

    clkdiv_update_unit #(.NUM_SRC(2)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_busy(data_busy), .card_clk(card_clk)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    live = 1'b0;
    bit    done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_pend, m_upd, m_hold, m_lock;
    bit m_stg_en, m_act_en, m_stg_src, m_act_src;
    int m_stg_div [2];
    int m_act_div [2];
    bit m_q, m_run_en;
    int m_run_d, m_left;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_upd = 0; m_hold = 0; m_lock = 0;
            m_stg_en = 0; m_act_en = 0; m_stg_src = 0; m_act_src = 0;
            m_stg_div = '{0, 0}; m_act_div = '{0, 0};
        end else begin
            bit was_pend, go, take;
            int s0, s1;
            bit ssrc, sen;
            was_pend = m_pend;
            s0 = m_stg_div[0]; s1 = m_stg_div[1]; ssrc = m_stg_src; sen = m_stg_en;
            go   = wr_en && addr == 3'd3 && wdata[31];
            take = was_pend && !(m_hold && data_busy);
            if (take) begin
                m_pend = 0;
                if (m_upd) begin
                    m_act_div[0] = s0; m_act_div[1] = s1;
                    m_act_src = ssrc; m_act_en = sen;
                end
            end
            if (go && !was_pend) begin
                m_pend = 1; m_upd = wdata[21]; m_hold = wdata[13];
            end
            if (go && was_pend) m_lock = 1;
            else if (wr_en && addr == 3'd4 && wdata[12]) m_lock = 0;
            if (wr_en && addr == 3'd0) begin
                m_stg_div[0] = int'(wdata[7:0]); m_stg_div[1] = int'(wdata[15:8]);
            end
            if (wr_en && addr == 3'd1) m_stg_src = wdata[0];
            if (wr_en && addr == 3'd2) m_stg_en = wdata[0];
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            m_q = 0; m_run_en = 0; m_run_d = 0; m_left = 0;
        end else begin
            int want;
            want = m_act_div[m_act_src];
            if (!m_q && (m_act_en != m_run_en || want != m_run_d)) begin
                m_run_en = m_act_en; m_run_d = want; m_q = 0; m_left = want;
            end else if (!m_run_en || m_run_d == 0) begin
                m_q = 0;
            end else begin
                m_left--;
                if (m_left == 0) begin
                    m_q = !m_q; m_left = m_run_d;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            3'd0: v = {16'd0, 8'(m_stg_div[1]), 8'(m_stg_div[0])};
            3'd1: v[0] = m_stg_src;
            3'd2: v[0] = m_stg_en;
            3'd3: begin v[31] = m_pend; v[21] = m_upd; v[13] = m_hold; end
            3'd4: v[12] = m_lock;
            3'd5: v[9] = data_busy;
            default: v = '0;
        endcase
        return v;
    endfunction

    // per-cycle comparison against the model
    always @(posedge clk) begin
        if (live) begin
            #0.5 check({phase, " card_clk high phase"}, 32'(card_clk),
                       32'((m_run_en && m_run_d == 0) ? 1'b1 : m_q));
            #2   check({phase, " card_clk low phase"}, 32'(card_clk), 32'(m_q));
            #1   check({phase, " rdata"}, rdata, exp_rd(addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #2.5 v = rdata;
        @(posedge clk); #1;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic measure(input int w, output int rises, output int highs, output int minrun);
        bit prev, cur, started;
        int run;
        rises = 0; highs = 0; minrun = 1 << 20; run = 0; started = 0; prev = 0;
        for (int i = 0; i <= w; i++) begin
            @(posedge clk); #0.5;
            cur = card_clk;
            if (i > 0 && cur && !prev) rises++;
            if (i < w && cur) highs++;
            if (i > 0) begin
                if (cur && !prev) begin started = 1; run = 1; end
                else if (cur && prev) run++;
                else if (!cur && prev && started && run < minrun) minrun = run;
            end
            prev = cur;
        end
        @(posedge clk); #1;
    endtask

    task automatic bypass_chk(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #0.5 check("R6 pass-through high", 32'(card_clk), 32'd1);
            #2   check("R6 pass-through low", 32'(card_clk), 32'd0);
        end
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int r, h, mr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        live = 1'b1;

        phase = "R1";
        for (int a = 0; a < 6; a++) rd_chk("R1 reset register", 3'(a), 32'd0);
        check("R1 reset card_clk", 32'(card_clk), 32'd0);

        phase = "R2";
        wr(3'd0, 32'd3); wr(3'd1, 32'd0); wr(3'd2, 32'd1);
        rd_chk("R2 divider readback", 3'd0, 32'd3);
        rd_chk("R2 gate readback", 3'd2, 32'd1);
        measure(20, r, h, mr);
        check("R2 staged only, no clock", 32'(h), 32'd0);

        phase = "R3";
        wr(3'd3, GO | UPD);
        rd_chk("R3 start bit pending", 3'd3, GO | UPD);
        rd_chk("R3 start bit self-clears", 3'd3, UPD);

        phase = "R5";
        idle(12);
        measure(24, r, h, mr);
        check("R4 R5 rises div3", 32'(r), 32'd4);
        check("R5 highs div3", 32'(h), 32'd12);
        wr(3'd0, 32'd255); wr(3'd3, GO | UPD);
        idle(10);
        measure(510, r, h, mr);
        check("R5 rises div255", 32'(r), 32'd1);
        check("R5 highs div255", 32'(h), 32'd255);

        phase = "R8";
        wr(3'd0, 32'h0000_0105); wr(3'd1, 32'd1); wr(3'd3, GO | UPD);
        idle(300);
        measure(20, r, h, mr);
        check("R8 selector 1 rises", 32'(r), 32'd10);
        wr(3'd1, 32'd0); wr(3'd3, GO | UPD);
        idle(10);
        measure(40, r, h, mr);
        check("R8 selector 0 rises", 32'(r), 32'd4);

        phase = "R6";
        wr(3'd0, 32'h0000_0100); wr(3'd3, GO | UPD);
        idle(12);
        bypass_chk(16);

        phase = "R7";
        wr(3'd2, 32'd0); wr(3'd3, GO | UPD);
        idle(5);
        measure(16, r, h, mr);
        check("R7 gate off highs", 32'(h), 32'd0);

        phase = "R9";
        wr(3'd2, 32'd1); wr(3'd0, 32'h0000_0106);
        data_busy = 1'b1;
        wr(3'd3, GO | UPD | HLD);
        wr(3'd3, GO);
        rd_chk("R9 lock flag set", 3'd4, 32'h0000_1000);
        rd_chk("R9 R10 second command dropped, first deferred", 3'd3, GO | UPD | HLD);
        data_busy = 1'b0;
        idle(1);
        rd_chk("R10 accepted once busy drops", 3'd3, UPD | HLD);
        rd_chk("R9 lock flag sticky", 3'd4, 32'h0000_1000);
        wr(3'd4, 32'h0000_1000);
        rd_chk("R9 lock flag cleared", 3'd4, 32'd0);
        idle(10);
        measure(24, r, h, mr);
        check("R9 deferred update applied", 32'(r), 32'd2);

        phase = "R10";
        data_busy = 1'b1;
        wr(3'd0, 32'h0000_0102); wr(3'd3, GO | UPD);
        rd_chk("R10 pending without hold", 3'd3, GO | UPD);
        rd_chk("R10 busy ignored without hold", 3'd3, UPD);
        rd_chk("R10 status busy bit", 3'd5, 32'h0000_0200);
        data_busy = 1'b0;
        idle(12);
        measure(16, r, h, mr);
        check("R10 applied under busy", 32'(r), 32'd4);

        phase = "R11";
        wr(3'd0, 32'h0000_0107); wr(3'd3, GO);
        rd_chk("R11 plain command pending", 3'd3, GO);
        idle(20);
        measure(16, r, h, mr);
        check("R11 clock unchanged", 32'(r), 32'd4);
        rd_chk("R11 staged value kept", 3'd0, 32'h0000_0107);

        phase = "R12";
        wr(3'd0, 32'h0000_0104); wr(3'd3, GO | UPD);
        idle(20);
        wr(3'd0, 32'h0000_0102);
        idle(3);
        wr(3'd3, GO | UPD);
        measure(40, r, h, mr);
        check("R12 no short high pulse", 32'(mr >= 2), 32'd1);
        measure(16, r, h, mr);
        check("R12 new rate after switch", 32'(r), 32'd4);

        live = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule